// File: doc/BRIEF.md
# Bundle-Indexed Program Counter Sequencer

This block holds the instruction pointer for a front end whose code is packed into fixed-size bundles. Each bundle carries a variable number of instructions, and its header states the index of its final instruction. The pointer therefore has two parts: a bundle number and a slot index inside that bundle. It is not a byte counter. Each sequential step moves to the next slot. When the current slot is the bundle's final one, the step moves to slot zero of the following bundle. Because no instruction spans two bundles, the bundle number alone gives the fetch address: the bundle number shifted left by the log2 of the bundle size in bytes.

A branch loads a target bundle and slot. The slot cannot be trusted until the target bundle's final-index count is known. After a branch the sequencer therefore waits in a checking mode until the count input is flagged valid. If the target slot lies past the bundle's final instruction, the sequencer latches an error and freezes the pointer. Every change of bundle number raises a one-cycle fetch request for the new bundle.

Top module: `bundle_pc_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the bundle number to 0, the slot index to 0, and clears the fetch request and the error flag.
- R2: In run mode, an edge with `advance_i` and `cnt_vld_i` high and the slot below `last_idx_i` increments the slot by one. The bundle is unchanged and there is no fetch request.
- R3: In run mode, an edge with `advance_i` and `cnt_vld_i` high and the slot equal to (or above) `last_idx_i` sets the slot to 0 and increments the bundle number modulo 2^BUNDLE_W. `fetch_req_o` is then high for exactly the following cycle.
- R4: An advance while `cnt_vld_i` is low has no effect on the pointer.
- R5: A branch (`br_req_i`) loads `br_bundle_i` and `br_idx_i` at the next edge and enters checking mode. `fetch_req_o` pulses only if the target bundle differs from the current one.
- R6: When a branch and an advance arrive in the same cycle, the branch wins and the advance is discarded.
- R7: In checking mode, advances are ignored. The first edge with `cnt_vld_i` high resolves the check and does not step. A target slot less than or equal to `last_idx_i` returns the sequencer to run mode.
- R8: If the check finds the target slot greater than `last_idx_i`, `br_err_o` goes high one cycle later. It stays high until reset, and while it is high the pointer ignores advances and branches.
- R9: `byte_addr_o` always equals the bundle number shifted left by BYTE_SHIFT (4, for 16-byte bundles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| last_idx_i | input | IDX_W | Final-instruction index of the bundle currently addressed |
| cnt_vld_i | input | 1 | `last_idx_i` is valid this cycle |
| advance_i | input | 1 | Step to the next instruction |
| br_req_i | input | 1 | Branch redirect request |
| br_bundle_i | input | BUNDLE_W | Branch target bundle number |
| br_idx_i | input | IDX_W | Branch target slot index |
| bundle_o | output | BUNDLE_W | Current bundle number |
| idx_o | output | IDX_W | Current slot index |
| byte_addr_o | output | BUNDLE_W+BYTE_SHIFT | Byte address of the current bundle |
| fetch_req_o | output | 1 | One-cycle request to fetch the bundle just entered |
| br_err_o | output | 1 | Sticky flag: branch slot beyond its bundle's last instruction |

## Verification
The bench targets the wrap point: a slot equal to the final index, a bundle whose final index is 0 so that every step wraps, and a bundle counter at its maximum rolling over to zero. A design that compared with the wrong bound would run one slot too far or too short, and one without modular wrap would not return to zero. The range check is probed at equality, which must pass, and one beyond, which must latch the error. The bench also confirms that a same-bundle branch raises no fetch. It checks that the resolving cycle does not step and that a frozen pointer ignores later branches. A design that mishandled these would issue redundant fetches, skip a slot, or escape the error state.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_CHECK = 2'd1,
        MODE_FAULT = 2'd2
    } bpc_mode_e;
endpackage

// File: rtl/bpc_step.sv
// Sequential successor of a (bundle, slot) pointer.
module bpc_step #(
    parameter int BUNDLE_W = 28,
    parameter int IDX_W    = 3
) (
    input  logic [BUNDLE_W-1:0] cur_bundle,
    input  logic [IDX_W-1:0]    cur_idx,
    input  logic [IDX_W-1:0]    last_idx,
    output logic [BUNDLE_W-1:0] nxt_bundle,
    output logic [IDX_W-1:0]    nxt_idx,
    output logic                wrap
);
    localparam logic [BUNDLE_W-1:0] BUNDLE_ONE = {{(BUNDLE_W-1){1'b0}}, 1'b1};
    localparam logic [IDX_W-1:0]    IDX_ONE    = {{(IDX_W-1){1'b0}}, 1'b1};

    always_comb begin
        wrap = (cur_idx >= last_idx);
        if (wrap) begin
            nxt_bundle = cur_bundle + BUNDLE_ONE;
            nxt_idx    = '0;
        end else begin
            nxt_bundle = cur_bundle;
            nxt_idx    = cur_idx + IDX_ONE;
        end
    end
endmodule

// File: rtl/bpc_range_chk.sv
// Flags a slot index that lies past the final slot of its bundle.
module bpc_range_chk #(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] slot_idx,
    input  logic [IDX_W-1:0] last_idx,
    output logic             beyond
);
    always_comb beyond = (slot_idx > last_idx);
endmodule

// File: rtl/bundle_pc_seq.sv
module bundle_pc_seq
    import bpc_pkg::*;
#(
    parameter int BUNDLE_W   = 28,
    parameter int IDX_W      = 3,
    parameter int BYTE_SHIFT = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [IDX_W-1:0]               last_idx_i,
    input  logic                           cnt_vld_i,
    input  logic                           advance_i,
    input  logic                           br_req_i,
    input  logic [BUNDLE_W-1:0]            br_bundle_i,
    input  logic [IDX_W-1:0]               br_idx_i,
    output logic [BUNDLE_W-1:0]            bundle_o,
    output logic [IDX_W-1:0]               idx_o,
    output logic [BUNDLE_W+BYTE_SHIFT-1:0] byte_addr_o,
    output logic                           fetch_req_o,
    output logic                           br_err_o
);
    localparam int ADDR_W = BUNDLE_W + BYTE_SHIFT;

    typedef struct packed {
        logic [BUNDLE_W-1:0] bundle;
        logic [IDX_W-1:0]    idx;
        bpc_mode_e           mode;
        logic                fetch;
    } pc_state_t;

    pc_state_t st_d, st_q;

    logic [BUNDLE_W-1:0] seq_bundle;
    logic [IDX_W-1:0]    seq_idx;
    logic                seq_wrap;
    logic                slot_beyond;

    bpc_step #(.BUNDLE_W(BUNDLE_W), .IDX_W(IDX_W)) u_step (
        .cur_bundle (st_q.bundle),
        .cur_idx    (st_q.idx),
        .last_idx   (last_idx_i),
        .nxt_bundle (seq_bundle),
        .nxt_idx    (seq_idx),
        .wrap       (seq_wrap)
    );

    bpc_range_chk #(.IDX_W(IDX_W)) u_chk (
        .slot_idx (st_q.idx),
        .last_idx (last_idx_i),
        .beyond   (slot_beyond)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fetch = 1'b0;
        if (st_q.mode != MODE_FAULT) begin
            if (br_req_i) begin
                st_d.bundle = br_bundle_i;
                st_d.idx    = br_idx_i;
                st_d.mode   = MODE_CHECK;
                st_d.fetch  = (br_bundle_i != st_q.bundle);
            end else if (st_q.mode == MODE_CHECK) begin
                if (cnt_vld_i) begin
                    st_d.mode = slot_beyond ? MODE_FAULT : MODE_RUN;
                end
            end else if (advance_i && cnt_vld_i) begin
                st_d.bundle = seq_bundle;
                st_d.idx    = seq_idx;
                st_d.fetch  = seq_wrap;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.bundle <= '0;
            st_q.idx    <= '0;
            st_q.mode   <= MODE_RUN;
            st_q.fetch  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bundle_o    = st_q.bundle;
    assign idx_o       = st_q.idx;
    assign byte_addr_o = {st_q.bundle, {BYTE_SHIFT{1'b0}}};
    assign fetch_req_o = st_q.fetch;
    assign br_err_o    = (st_q.mode == MODE_FAULT);

    // ---------------- assertions ----------------
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (bundle_o == '0 && idx_o == '0 && !fetch_req_o && !br_err_o));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_RUN && advance_i && cnt_vld_i && !br_req_i && idx_o < last_idx_i)
        |=> (idx_o == $past(idx_o) + 1'b1 && $stable(bundle_o) && !fetch_req_o));

    assert_wrap_next_bundle_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_RUN && advance_i && cnt_vld_i && !br_req_i && idx_o >= last_idx_i)
        |=> (idx_o == '0 && bundle_o == $past(bundle_o) + 1'b1 && fetch_req_o));

    assert_no_step_without_count_R4: assert property (@(posedge clk) disable iff (rst)
        (!br_req_i && !cnt_vld_i) |=> ($stable(bundle_o) && $stable(idx_o)));

    assert_branch_loads_R6: assert property (@(posedge clk) disable iff (rst)
        (br_req_i && !br_err_o) |=> (bundle_o == $past(br_bundle_i) && idx_o == $past(br_idx_i)));

    assert_fetch_only_on_change_R5: assert property (@(posedge clk) disable iff (rst)
        fetch_req_o |-> !$stable(bundle_o));

    assert_change_raises_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(bundle_o) |-> fetch_req_o);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        br_err_o |=> (br_err_o && $stable(bundle_o) && $stable(idx_o)));

    assert_check_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_CHECK && !br_req_i) |=> ($stable(bundle_o) && $stable(idx_o)));

    always_comb begin
        assert_byte_addr_R9: assert (byte_addr_o[ADDR_W-1:BYTE_SHIFT] == bundle_o
                                     && byte_addr_o[BYTE_SHIFT-1:0] == '0);
    end
endmodule

// File: tb/tb_bundle_pc_seq.sv
`timescale 1ns/1ps
module tb_bundle_pc_seq;
    localparam int BW = 28;
    localparam int IW = 3;
    localparam int BS = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [IW-1:0] last_idx;
    logic          cnt_vld, advance, br_req;
    logic [BW-1:0] br_bundle;
    logic [IW-1:0] br_idx;
    logic [BW-1:0] bundle;
    logic [IW-1:0] idx;
    logic [BW+BS-1:0] byte_addr;
    logic          fetch_req, br_err;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bundle_pc_seq #(.BUNDLE_W(BW), .IDX_W(IW), .BYTE_SHIFT(BS)) dut (
        .clk(clk), .rst(rst), .last_idx_i(last_idx), .cnt_vld_i(cnt_vld),
        .advance_i(advance), .br_req_i(br_req), .br_bundle_i(br_bundle),
        .br_idx_i(br_idx), .bundle_o(bundle), .idx_o(idx),
        .byte_addr_o(byte_addr), .fetch_req_o(fetch_req), .br_err_o(br_err)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, sample just after the next rising edge.
    task automatic cyc(input bit r, input bit adv, input bit vld, input int last,
                       input bit br, input longint bb, input int bi);
        @(negedge clk);
        rst = r; advance = adv; cnt_vld = vld; last_idx = IW'(last);
        br_req = br; br_bundle = BW'(bb); br_idx = IW'(bi);
        @(posedge clk);
        #1;
    endtask

    task automatic expect_ptr(input string req, input longint b, input int i,
                              input bit f, input bit e);
        chk({req, " bundle"}, bundle, b);
        chk({req, " idx"}, idx, i);
        chk({req, " fetch"}, fetch_req, f);
        chk({req, " err"}, br_err, e);
        chk("R9 byte_addr", byte_addr, b << BS);
    endtask

    task automatic t_reset();
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 1, 1, 0, 1, 5, 1);
        expect_ptr("R1 reset", 0, 0, 0, 0);
    endtask

    task automatic t_sequential();
        cyc(0, 1, 1, 3, 0, 0, 0); expect_ptr("R2 step1", 0, 1, 0, 0);
        cyc(0, 1, 1, 3, 0, 0, 0); expect_ptr("R2 step2", 0, 2, 0, 0);
        cyc(0, 1, 1, 3, 0, 0, 0); expect_ptr("R2 step3", 0, 3, 0, 0);
        cyc(0, 1, 1, 3, 0, 0, 0); expect_ptr("R3 wrap", 1, 0, 1, 0);
        cyc(0, 0, 1, 3, 0, 0, 0); expect_ptr("R3 pulse ends", 1, 0, 0, 0);
    endtask

    task automatic t_no_count();
        cyc(0, 1, 0, 3, 0, 0, 0); expect_ptr("R4 advance no count", 1, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0, 0); expect_ptr("R4 advance no count 2", 1, 0, 0, 0);
    endtask

    task automatic t_last_zero();
        cyc(0, 1, 1, 0, 0, 0, 0); expect_ptr("R3 last0 wrap a", 2, 0, 1, 0);
        cyc(0, 1, 1, 0, 0, 0, 0); expect_ptr("R3 last0 wrap b", 3, 0, 1, 0);
    endtask

    task automatic t_branch();
        cyc(0, 0, 0, 0, 1, 'h100, 5); expect_ptr("R5 branch", 'h100, 5, 1, 0);
        cyc(0, 1, 1, 6, 0, 0, 0);     expect_ptr("R7 resolve no step", 'h100, 5, 0, 0);
        cyc(0, 1, 1, 6, 0, 0, 0);     expect_ptr("R2 after resolve", 'h100, 6, 0, 0);
        cyc(0, 1, 1, 6, 0, 0, 0);     expect_ptr("R3 after branch", 'h101, 0, 1, 0);
    endtask

    task automatic t_same_bundle_priority();
        cyc(0, 1, 1, 7, 1, 'h101, 2); expect_ptr("R6 branch over advance", 'h101, 2, 0, 0);
        cyc(0, 1, 1, 7, 0, 0, 0);     expect_ptr("R7 resolve", 'h101, 2, 0, 0);
        cyc(0, 1, 1, 7, 0, 0, 0);     expect_ptr("R2 step", 'h101, 3, 0, 0);
    endtask

    task automatic t_check_wait_equal();
        cyc(0, 0, 0, 0, 1, 'h200, 4); expect_ptr("R5 branch b", 'h200, 4, 1, 0);
        cyc(0, 1, 0, 4, 0, 0, 0);     expect_ptr("R7 wait count", 'h200, 4, 0, 0);
        cyc(0, 1, 1, 4, 0, 0, 0);     expect_ptr("R7 equal passes", 'h200, 4, 0, 0);
        cyc(0, 1, 1, 4, 0, 0, 0);     expect_ptr("R3 wrap at equal", 'h201, 0, 1, 0);
    endtask

    task automatic t_counter_rollover();
        cyc(0, 0, 0, 0, 1, 'hFFFFFFF, 0); expect_ptr("R5 branch max", 'hFFFFFFF, 0, 1, 0);
        cyc(0, 0, 1, 0, 0, 0, 0);         expect_ptr("R7 resolve max", 'hFFFFFFF, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 0, 0);         expect_ptr("R3 rollover", 0, 0, 1, 0);
    endtask

    task automatic t_error();
        cyc(0, 0, 0, 0, 1, 'h300, 6); expect_ptr("R5 branch c", 'h300, 6, 1, 0);
        cyc(0, 0, 1, 5, 0, 0, 0);     expect_ptr("R8 beyond by one", 'h300, 6, 0, 1);
        cyc(0, 1, 1, 7, 0, 0, 0);     expect_ptr("R8 advance ignored", 'h300, 6, 0, 1);
        cyc(0, 0, 0, 0, 1, 'h10, 0);  expect_ptr("R8 branch ignored", 'h300, 6, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);     expect_ptr("R8 sticky", 'h300, 6, 0, 1);
        cyc(1, 0, 0, 0, 0, 0, 0);     expect_ptr("R1 reset clears err", 0, 0, 0, 0);
    endtask

    initial begin
        rst = 1'b1; advance = 0; cnt_vld = 0; last_idx = '0;
        br_req = 0; br_bundle = '0; br_idx = '0;
        t_reset();
        t_sequential();
        t_no_count();
        t_last_zero();
        t_branch();
        t_same_bundle_priority();
        t_check_wait_equal();
        t_counter_rollover();
        t_error();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule